// File: doc/BRIEF.md
# Control-Word Register-ALU Datapath

This block is a small datapath steered entirely by a horizontal control word that arrives on its pins every clock cycle. It holds three general registers, two operand latches that feed a four-function ALU, an input port and a registered output port. There is no decoder and no sequencing logic inside. Whatever drives the control pins decides the order of operations, which makes the block a convenient target for step-by-step programs that load, route, compute and observe values.

Each control word has five fields. One field picks the write-back source: the ALU result or the input port. A second names the register that is written. A third names the register placed on the read bus. A fourth picks the ALU function. The last sends the read bus to the output port or to one of the two operand latches. The register write and the read-side update share one clock edge. The read bus always carries register contents from before that edge, so a value can be written and the old value observed in the same step.

Top module: `regalu_datapath`

## Requirements
- R1: After synchronous reset (rst high at a clock edge), the three registers, both operand latches and dout are zero.
- R2: With wr_dst equal to 0, 1 or 2, that register takes the write-back value at the clock edge. The write-back value is din when wb_from_in is 1 and the ALU result when it is 0.
- R3: wr_dst equal to 3 writes no register.
- R4: rd_src equal to 0, 1 or 2 places that register on the read bus. rd_src equal to 3 places zero on it.
- R5: rd_route 0 loads the read bus into dout, 1 loads it into operand latch B, and 2 loads it into operand latch A.
- R6: rd_route 3 leaves dout, latch A and latch B unchanged.
- R7: alu_fn selects the ALU result, taken modulo 2^W: 0 gives A, 1 gives the bitwise complement of B, 2 gives A+B and 3 gives A-B.
- R8: The read bus carries register values from before the clock edge, so a register that is written and read in the same cycle shows its old value on dout.
- R9: The sequence load R0 from din, route R0 into A, write the A pass-through into R1, then route R1 to dout, reproduces the original din value on dout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wb_from_in | input | 1 | Write-back source: 1 selects din, 0 selects the ALU result |
| wr_dst | input | 2 | Destination register 0..2; 3 writes nothing |
| rd_src | input | 2 | Register driven onto the read bus 0..2; 3 gives zero |
| alu_fn | input | 2 | ALU function: A, ~B, A+B, A-B |
| rd_route | input | 2 | Read-bus destination: dout, latch B, latch A, or none |
| din | input | W | Input data port |
| dout | output | W | Registered output port |

## Verification
The ALU is swept over a grid of operand pairs that includes zero, all ones and nibble patterns. Every pair goes through all four functions, so any wrong function code, carry or borrow shows up as a wrong value read back through a register. Each register is loaded with a distinct value and read back on its own, which catches a crossed or duplicated destination or source decode. A null destination is followed by reads of all three registers, and null routing is followed by ALU pass-through reads of both latches. These steps show that the idle codes touch nothing. A write and a read of the same register in one step separates read-before-write timing from a bypass, and the load, latch, pass and read sequence checks the full path from din to dout.

// File: rtl/regalu_datapath.sv
module regalu_datapath #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wb_from_in,
  input  logic [1:0]   wr_dst,
  input  logic [1:0]   rd_src,
  input  logic [1:0]   alu_fn,
  input  logic [1:0]   rd_route,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NREG = 3;

  logic [W-1:0] rf [NREG];
  logic [W-1:0] opa, opb, alu_y, wb_bus, rd_bus;

  always_comb begin
    case (alu_fn)
      2'd0:    alu_y = opa;
      2'd1:    alu_y = ~opb;
      2'd2:    alu_y = opa + opb;
      default: alu_y = opa - opb;
    endcase
  end

  assign wb_bus = wb_from_in ? din : alu_y;

  always_comb begin
    case (rd_src)
      2'd0:    rd_bus = rf[0];
      2'd1:    rd_bus = rf[1];
      2'd2:    rd_bus = rf[2];
      default: rd_bus = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)                 rf[i] <= '0;
      else if (wr_dst == 2'(i)) rf[i] <= wb_bus;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opa  <= '0;
      opb  <= '0;
      dout <= '0;
    end else begin
      case (rd_route)
        2'd0:    dout <= rd_bus;
        2'd1:    opb  <= rd_bus;
        2'd2:    opa  <= rd_bus;
        default: ;
      endcase
    end
  end

  AST_IN_WRITE_R0: assert property (@(posedge clk) disable iff (rst)
    (wb_from_in && wr_dst == 2'd0) |=> rf[0] == $past(din)); // R2

  AST_NULL_DST: assert property (@(posedge clk) disable iff (rst)
    (wr_dst == 2'd3) |=> ($stable(rf[0]) && $stable(rf[1]) && $stable(rf[2]))); // R3

  AST_ROUTE_OUT: assert property (@(posedge clk) disable iff (rst)
    (rd_route == 2'd0) |=> dout == $past(rd_bus)); // R5

  AST_ROUTE_A: assert property (@(posedge clk) disable iff (rst)
    (rd_route == 2'd2) |=> opa == $past(rd_bus)); // R5

  AST_ROUTE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (rd_route == 2'd3) |=> ($stable(dout) && $stable(opa) && $stable(opb))); // R6

  AST_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_src == 2'd3 && rd_route == 2'd0) |=> dout == '0); // R4
endmodule

// File: tb/regalu_datapath_bench.sv
`timescale 1ns/1ps
module regalu_datapath_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wb_from_in = 1'b0;
  logic [1:0]   wr_dst = 2'd3;
  logic [1:0]   rd_src = 2'd3;
  logic [1:0]   alu_fn = 2'd0;
  logic [1:0]   rd_route = 2'd3;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  regalu_datapath #(.W(W)) u_regalu_datapath (
    .clk(clk), .rst(rst), .wb_from_in(wb_from_in), .wr_dst(wr_dst),
    .rd_src(rd_src), .alu_fn(alu_fn), .rd_route(rd_route),
    .din(din), .dout(dout)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=fewer", cycles);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
    end
  end

  task automatic step(input logic wb, input logic [1:0] dst, input logic [1:0] src,
                      input logic [1:0] fn, input logic [1:0] rt, input logic [W-1:0] d);
    @(negedge clk);
    wb_from_in = wb; wr_dst = dst; rd_src = src; alu_fn = fn; rd_route = rt; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] r, input logic [W-1:0] v);
    step(1'b1, r, 2'd3, 2'd0, 2'd3, v);
  endtask

  task automatic read_reg(input logic [1:0] r, input string tag, input logic [W-1:0] exp);
    step(1'b0, 2'd3, r, 2'd0, 2'd0, '0);
    check(tag, dout, exp);
  endtask

  function automatic logic [W-1:0] ref_alu(input logic [1:0] fn, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    case (fn)
      2'd0:    return a;
      2'd1:    return ~b;
      2'd2:    return W'(a + b);
      default: return W'(a - b);
    endcase
  endfunction

  initial begin
    step(1'b0, 2'd3, 2'd3, 2'd0, 2'd3, '0);
    step(1'b0, 2'd3, 2'd3, 2'd0, 2'd3, '0);
    check("R1 dout after reset", dout, '0);
    rst = 1'b0;
    read_reg(2'd0, "R1 r0 after reset", '0);
    read_reg(2'd1, "R1 r1 after reset", '0);
    read_reg(2'd2, "R1 r2 after reset", '0);
    step(1'b0, 2'd2, 2'd3, 2'd2, 2'd3, '0);
    read_reg(2'd2, "R1 latches zero after reset", '0);

    load(2'd0, 8'h11); load(2'd1, 8'h22); load(2'd2, 8'h33);
    read_reg(2'd0, "R2 r0 from din", 8'h11);
    read_reg(2'd1, "R2 r1 from din", 8'h22);
    read_reg(2'd2, "R2 r2 from din", 8'h33);
    read_reg(2'd3, "R4 null source reads zero", '0);

    step(1'b1, 2'd3, 2'd3, 2'd0, 2'd3, 8'hFF);
    step(1'b0, 2'd3, 2'd3, 2'd2, 2'd3, 8'hEE);
    read_reg(2'd0, "R3 r0 untouched", 8'h11);
    read_reg(2'd1, "R3 r1 untouched", 8'h22);
    read_reg(2'd2, "R3 r2 untouched", 8'h33);

    step(1'b0, 2'd3, 2'd0, 2'd0, 2'd2, '0);
    step(1'b0, 2'd3, 2'd1, 2'd0, 2'd1, '0);
    read_reg(2'd2, "R6 dout preset", 8'h33);
    step(1'b1, 2'd2, 2'd0, 2'd0, 2'd3, 8'h44);
    check("R6 dout held", dout, 8'h33);
    step(1'b0, 2'd3, 2'd1, 2'd0, 2'd3, '0);
    check("R6 dout held again", dout, 8'h33);
    step(1'b0, 2'd2, 2'd3, 2'd0, 2'd3, '0);
    read_reg(2'd2, "R6 latch A held", 8'h11);
    step(1'b0, 2'd2, 2'd3, 2'd1, 2'd3, '0);
    read_reg(2'd2, "R6 latch B held", ~8'h22);

    read_reg(2'd0, "R8 preset dout", 8'h11);
    step(1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 8'h99);
    check("R8 same-edge read sees old value", dout, 8'h11);
    read_reg(2'd0, "R8 new value afterwards", 8'h99);

    for (int k = 0; k < 4; k++) begin
      logic [W-1:0] v;
      v = W'(k * 83 + 5);
      load(2'd0, v);
      step(1'b0, 2'd3, 2'd0, 2'd0, 2'd2, '0);
      step(1'b0, 2'd1, 2'd3, 2'd0, 2'd3, '0);
      read_reg(2'd1, "R9 din to dout path", v);
    end

    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [W-1:0] a, b;
        a = W'(i * 17);
        b = W'(j * 29 + 7);
        if (j == 15) b = 8'hFF;
        load(2'd0, a);
        load(2'd1, b);
        step(1'b0, 2'd3, 2'd0, 2'd0, 2'd2, '0);
        step(1'b0, 2'd3, 2'd1, 2'd0, 2'd1, '0);
        for (int f = 0; f < 4; f++) begin
          step(1'b0, 2'd2, 2'd3, 2'(f), 2'd3, '0);
          read_reg(2'd2, "R7 alu sweep", ref_alu(2'(f), a, b));
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule